// File: doc/BRIEF.md
# Ethernet DMA Status and Interrupt Register Block

This block is the control and status register file that sits beside an Ethernet DMA engine. Software reaches it over a plain word-addressed bus with a write strobe and a combinational read-data path. The DMA engines report transmit and receive events as single-cycle pulses. Each pulse sets its own status bit and a summary bit. Software acknowledges events by writing ones to the status register. A single level-sensitive interrupt line is raised while any enabled status bit is set.

The block also holds the bus mode, control, interrupt enable and the two descriptor list base registers. Writing a list base register also reloads the matching live descriptor pointer, which the DMA engines read from the block's outputs. Two control bits start the receive and transmit engines.

Register map (word addresses):
- 0 bus mode
- 1 control
- 2 status
- 3 interrupt enable
- 4 receive list base
- 5 transmit list base
- 6 current receive descriptor pointer, read-only
- 7 current transmit descriptor pointer, read-only

Top module: `dma_csr_block`

## Requirements
- R1: After the active-low reset every register, both pointer outputs, `rx_run`, `tx_run` and `irq` are zero.
- R2: A bus write to address 2 clears every status bit that is 1 in the written data and leaves every other status bit unchanged.
- R3: Event pulses set status bits on the next clock edge:
  - `evt_tx_done` sets bit 0 and bit 16.
  - `evt_tx_stop` sets bit 1 and bit 15.
  - `evt_tx_nobuf` sets bit 2 and bit 16.
  - `evt_rx_done` sets bit 6 and bit 16.
  - `evt_rx_nobuf` sets bit 7 and bit 15.
  
  A set arriving in the same cycle as a software clear of that bit wins.
- R4: `irq` is registered: one cycle after the status or enable registers change, it equals the OR-reduction of (status AND interrupt enable).
- R5: A write to address 4 stores the value as the receive list base and also loads it into the current receive pointer (address 6, `cur_rx_ptr`). A write to address 5 does the same for the transmit side (address 7, `cur_tx_ptr`). Neither write touches the other side.
- R6: A write to address 0 stores the value with bit 0 forced to zero, so bit 0 never reads back as 1.
- R7: `rx_run` follows control bit 1 and `tx_run` follows control bit 13, from the edge that writes the control register.
- R8: A read of any address from 8 up returns zero, and a write there changes no register. Writes to addresses 6 and 7 are also ignored.
- R9: Status bits other than 0, 1, 2, 6, 7, 15 and 16 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| evt_tx_done | input | 1 | Transmit frame completed pulse |
| evt_tx_stop | input | 1 | Transmit engine stopped pulse |
| evt_tx_nobuf | input | 1 | Transmit descriptor unavailable pulse |
| evt_rx_done | input | 1 | Receive frame completed pulse |
| evt_rx_nobuf | input | 1 | Receive descriptor unavailable pulse |
| rx_run | output | 1 | Receive engine start (control bit 1) |
| tx_run | output | 1 | Transmit engine start (control bit 13) |
| cur_rx_ptr | output | DATA_W | Current receive descriptor pointer |
| cur_tx_ptr | output | DATA_W | Current transmit descriptor pointer |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, event pulses and the pointer loads all take effect at the first clock edge after they are driven. Read data is combinational, so the bench drives every stimulus at a falling edge and reads one falling edge later. The interrupt output lags the status and enable registers by one more edge. For that reason, each interrupt-enable sweep step first checks that `irq` still shows the previous enable one half cycle after the write edge, and only then checks the new value a full cycle later. Same-cycle set and clear collisions are driven in one write cycle, and their result is read at the following falling edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    // word addresses
    localparam int REG_MODE   = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_STAT   = 2;
    localparam int REG_IEN    = 3;
    localparam int REG_RXBASE = 4;
    localparam int REG_TXBASE = 5;
    localparam int REG_RXCUR  = 6;
    localparam int REG_TXCUR  = 7;
    localparam int NUM_REGS   = 8;

    // status bit positions
    localparam int ST_TXDONE  = 0;
    localparam int ST_TXSTOP  = 1;
    localparam int ST_TXNOBUF = 2;
    localparam int ST_RXDONE  = 6;
    localparam int ST_RXNOBUF = 7;
    localparam int ST_ABNSUM  = 15;
    localparam int ST_NRMSUM  = 16;

    // control bit positions
    localparam int CTRL_RXGO  = 1;
    localparam int CTRL_TXGO  = 13;

    // list pointer pair indices
    localparam int PTR_RX     = 0;
    localparam int PTR_TX     = 1;
    localparam int NUM_PTRS   = 2;

    typedef struct packed {
        logic rx_nobuf;
        logic rx_done;
        logic tx_nobuf;
        logic tx_stop;
        logic tx_done;
    } dma_evt_t;

endpackage

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_mask,
    input  dma_evt_t          evt,
    output logic [DATA_W-1:0] stat_o
);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] kill_mask;

    always_comb begin
        set_mask = '0;
        if (evt.tx_done) begin
            set_mask[ST_TXDONE] = 1'b1;
            set_mask[ST_NRMSUM] = 1'b1;
        end
        if (evt.tx_stop) begin
            set_mask[ST_TXSTOP] = 1'b1;
            set_mask[ST_ABNSUM] = 1'b1;
        end
        if (evt.tx_nobuf) begin
            set_mask[ST_TXNOBUF] = 1'b1;
            set_mask[ST_NRMSUM]  = 1'b1;
        end
        if (evt.rx_done) begin
            set_mask[ST_RXDONE] = 1'b1;
            set_mask[ST_NRMSUM] = 1'b1;
        end
        if (evt.rx_nobuf) begin
            set_mask[ST_RXNOBUF] = 1'b1;
            set_mask[ST_ABNSUM]  = 1'b1;
        end
    end

    assign kill_mask = clr_en ? clr_mask : '0;

    // set is applied after clear, so a colliding event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~kill_mask) | set_mask;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] ien,
    output logic              irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat & ien);
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/dma_csr_ptr_pair.sv
module dma_csr_ptr_pair #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] cur_o
);

    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            base_q <= value;
            cur_q  <= value;
        end
    end

    assign base_o = base_q;
    assign cur_o  = cur_q;

endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_tx_done,
    input  logic              evt_tx_stop,
    input  logic              evt_tx_nobuf,
    input  logic              evt_rx_done,
    input  logic              evt_rx_nobuf,
    output logic              rx_run,
    output logic              tx_run,
    output logic [DATA_W-1:0] cur_rx_ptr,
    output logic [DATA_W-1:0] cur_tx_ptr,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(REG_IEN);
    localparam logic [ADDR_W-1:0] A_RXBASE = ADDR_W'(REG_RXBASE);
    localparam logic [ADDR_W-1:0] A_TXBASE = ADDR_W'(REG_TXBASE);
    localparam logic [ADDR_W-1:0] A_RXCUR  = ADDR_W'(REG_RXCUR);
    localparam logic [ADDR_W-1:0] A_TXCUR  = ADDR_W'(REG_TXCUR);

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ien_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] base_a [NUM_PTRS];
    logic [DATA_W-1:0] cur_a  [NUM_PTRS];
    logic              ptr_load [NUM_PTRS];
    dma_evt_t          evt;

    assign evt = '{rx_nobuf: evt_rx_nobuf, rx_done: evt_rx_done,
                   tx_nobuf: evt_tx_nobuf, tx_stop: evt_tx_stop,
                   tx_done: evt_tx_done};

    // plain read/write registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_MODE:  mode_q <= {bus_wdata[DATA_W-1:1], 1'b0};
                A_CTRL:  ctrl_q <= bus_wdata;
                A_IEN:   ien_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    dma_csr_status #(.DATA_W(DATA_W)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr && (bus_addr == A_STAT)),
        .clr_mask (bus_wdata),
        .evt      (evt),
        .stat_o   (stat_q)
    );

    dma_csr_irq #(.DATA_W(DATA_W)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat_q),
        .ien   (ien_q),
        .irq_o (irq)
    );

    generate
        for (genvar gi = 0; gi < NUM_PTRS; gi++) begin : g_ptr
            localparam logic [ADDR_W-1:0] A_BASE = (gi == PTR_RX) ? A_RXBASE : A_TXBASE;
            assign ptr_load[gi] = bus_wr && (bus_addr == A_BASE);
            dma_csr_ptr_pair #(.DATA_W(DATA_W)) pair_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (ptr_load[gi]),
                .value  (bus_wdata),
                .base_o (base_a[gi]),
                .cur_o  (cur_a[gi])
            );
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            A_MODE:   bus_rdata = mode_q;
            A_CTRL:   bus_rdata = ctrl_q;
            A_STAT:   bus_rdata = stat_q;
            A_IEN:    bus_rdata = ien_q;
            A_RXBASE: bus_rdata = base_a[PTR_RX];
            A_TXBASE: bus_rdata = base_a[PTR_TX];
            A_RXCUR:  bus_rdata = cur_a[PTR_RX];
            A_TXCUR:  bus_rdata = cur_a[PTR_TX];
            default:  bus_rdata = '0;
        endcase
    end

    assign rx_run     = ctrl_q[CTRL_RXGO];
    assign tx_run     = ctrl_q[CTRL_TXGO];
    assign cur_rx_ptr = cur_a[PTR_RX];
    assign cur_tx_ptr = cur_a[PTR_TX];

endmodule

// File: rtl/dma_csr_block_chk.sv
module dma_csr_block_chk
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [4:0]        evt_vec,
    input logic [DATA_W-1:0] stat_q,
    input logic [DATA_W-1:0] ien_q,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] cur_rx_ptr,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_RXBASE = ADDR_W'(REG_RXBASE);

    // R2: clear without events
    a_r2_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && evt_vec == 5'd0)
            |=> (stat_q == ($past(stat_q) & ~$past(bus_wdata))));

    // R3: receive-done set wins, with its summary bit
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vec[3] |=> (stat_q[ST_RXDONE] && stat_q[ST_NRMSUM]));

    // R4: registered interrupt
    a_r4_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|($past(stat_q) & $past(ien_q))));

    // R5: receive base write loads the live pointer
    a_r5_rx_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RXBASE) |=> (cur_rx_ptr == $past(bus_wdata)));

    // R6: mode bit 0 never set
    a_r6_mode_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[0] == 1'b0);

    // R8: out-of-range reads are zero
    a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, bus_addr} >= (ADDR_W+1)'(NUM_REGS)) |-> (bus_rdata == '0));

endmodule

bind dma_csr_block dma_csr_block_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_vec    ({evt_rx_nobuf, evt_rx_done, evt_tx_nobuf, evt_tx_stop, evt_tx_done}),
    .stat_q     (stat_q),
    .ien_q      (ien_q),
    .mode_q     (mode_q),
    .cur_rx_ptr (cur_rx_ptr),
    .irq        (irq)
);

// File: tb/dma_csr_block_tb_top.sv
`timescale 1ns/1ps
module dma_csr_block_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  ev = '0;
    logic        rx_run, tx_run, irq;
    logic [31:0] cur_rx_ptr, cur_tx_ptr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dma_csr_block dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_tx_done(ev[0]), .evt_tx_stop(ev[1]), .evt_tx_nobuf(ev[2]),
        .evt_rx_done(ev[3]), .evt_rx_nobuf(ev[4]),
        .rx_run(rx_run), .tx_run(tx_run),
        .cur_rx_ptr(cur_rx_ptr), .cur_tx_ptr(cur_tx_ptr), .irq(irq)
    );

    function automatic logic [31:0] ev_mask(input logic [4:0] e);
        logic [31:0] m = '0;
        if (e[0]) m = m | 32'h0001_0001;
        if (e[1]) m = m | 32'h0000_8002;
        if (e[2]) m = m | 32'h0001_0004;
        if (e[3]) m = m | 32'h0001_0040;
        if (e[4]) m = m | 32'h0000_8080;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus, starting and ending at a falling edge
    task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d, input logic [4:0] e);
        bus_wr = w; bus_addr = a; bus_wdata = d; ev = e;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; ev = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_st;
        logic        prev_irq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), r);
            chk($sformatf("R1 reg %0d", a), r, 32'h0);
        end
        chk("R1 outputs", {28'h0, rx_run, tx_run, irq, |(cur_rx_ptr | cur_tx_ptr)}, 32'h0);

        // R3/R9 event sweep, enable zero so irq stays low
        exp_st = '0;
        for (int e = 0; e < 32; e++) begin
            cyc(1'b0, 4'd0, 32'h0, 5'(e));
            exp_st = exp_st | ev_mask(5'(e));
            rd(4'd2, r);
            chk($sformatf("R3 R9 events %0d", e), r, exp_st);
            chk("R4 irq masked", {31'h0, irq}, 32'h0);
            // R2 clear with a pattern derived from the step
            cyc(1'b1, 4'd2, (32'h0001_80C7 >> (e % 8)) | (32'(e) << 27), 5'd0);
            exp_st = exp_st & ~((32'h0001_80C7 >> (e % 8)) | (32'(e) << 27));
            rd(4'd2, r);
            chk($sformatf("R2 clear %0d", e), r, exp_st);
        end

        // R3 same-cycle clear of all bits against every event set
        for (int e = 0; e < 32; e++) begin
            cyc(1'b1, 4'd2, 32'hFFFF_FFFF, 5'(e));
            rd(4'd2, r);
            chk($sformatf("R3 set wins %0d", e), r, ev_mask(5'(e)));
        end
        cyc(1'b1, 4'd2, 32'hFFFF_FFFF, 5'd0);
        rd(4'd2, r);
        chk("R2 clear all", r, 32'h0);

        // R4 interrupt sweep over every enable bit
        cyc(1'b0, 4'd0, 32'h0, 5'h1F);
        exp_st = ev_mask(5'h1F);
        prev_irq = 1'b0;
        for (int j = 0; j < 32; j++) begin
            cyc(1'b1, 4'd3, 32'h1 << j, 5'd0);
            chk($sformatf("R4 irq lag bit %0d", j), {31'h0, irq}, {31'h0, prev_irq});
            cyc(1'b0, 4'd0, 32'h0, 5'd0);
            chk($sformatf("R4 irq bit %0d", j), {31'h0, irq}, {31'h0, exp_st[j]});
            prev_irq = exp_st[j];
        end
        // clearing the enabled status bit drops irq one cycle later (enable = bit 31 now)
        cyc(1'b1, 4'd3, 32'h0000_0040, 5'd0);
        cyc(1'b0, 4'd0, 32'h0, 5'd0);
        chk("R4 irq rx enabled", {31'h0, irq}, 32'h1);
        cyc(1'b1, 4'd2, 32'h0000_0040, 5'd0);
        chk("R4 irq after clear lag", {31'h0, irq}, 32'h1);
        cyc(1'b0, 4'd0, 32'h0, 5'd0);
        chk("R4 irq after clear", {31'h0, irq}, 32'h0);
        cyc(1'b1, 4'd3, 32'h0, 5'd0);
        cyc(1'b1, 4'd2, 32'hFFFF_FFFF, 5'd0);

        // R6 mode bit 0
        cyc(1'b1, 4'd0, 32'hFFFF_FFFF, 5'd0);
        rd(4'd0, r);
        chk("R6 mode all ones", r, 32'hFFFF_FFFE);
        cyc(1'b1, 4'd0, 32'h0000_0001, 5'd0);
        rd(4'd0, r);
        chk("R6 mode one", r, 32'h0);
        cyc(1'b1, 4'd0, 32'h1234_5679, 5'd0);
        rd(4'd0, r);
        chk("R6 mode pattern", r, 32'h1234_5678);

        // R7 control bits
        cyc(1'b1, 4'd1, 32'h0000_0002, 5'd0);
        chk("R7 rx only", {30'h0, rx_run, tx_run}, 32'h2);
        cyc(1'b1, 4'd1, 32'h0000_2000, 5'd0);
        chk("R7 tx only", {30'h0, rx_run, tx_run}, 32'h1);
        cyc(1'b1, 4'd1, 32'hFFFF_DFFD, 5'd0);
        chk("R7 others only", {30'h0, rx_run, tx_run}, 32'h0);
        cyc(1'b1, 4'd1, 32'h0000_2002, 5'd0);
        chk("R7 both", {30'h0, rx_run, tx_run}, 32'h3);

        // R5 list base loads
        cyc(1'b1, 4'd4, 32'h1000_0040, 5'd0);
        chk("R5 rx port", cur_rx_ptr, 32'h1000_0040);
        chk("R5 tx untouched", cur_tx_ptr, 32'h0);
        rd(4'd6, r);
        chk("R5 rx cur read", r, 32'h1000_0040);
        rd(4'd4, r);
        chk("R5 rx base read", r, 32'h1000_0040);
        cyc(1'b1, 4'd5, 32'h2000_0080, 5'd0);
        chk("R5 tx port", cur_tx_ptr, 32'h2000_0080);
        chk("R5 rx untouched", cur_rx_ptr, 32'h1000_0040);
        rd(4'd7, r);
        chk("R5 tx cur read", r, 32'h2000_0080);

        // R8 read-only pointers and out-of-range addresses
        cyc(1'b1, 4'd6, 32'hDEAD_BEEF, 5'd0);
        cyc(1'b1, 4'd7, 32'hDEAD_BEEF, 5'd0);
        chk("R8 cur rx ro", cur_rx_ptr, 32'h1000_0040);
        chk("R8 cur tx ro", cur_tx_ptr, 32'h2000_0080);
        for (int a = 8; a < 16; a++) begin
            cyc(1'b1, 4'(a), 32'hFFFF_FFFF, 5'd0);
            rd(4'(a), r);
            chk($sformatf("R8 oob read %0d", a), r, 32'h0);
        end
        rd(4'd0, r); chk("R8 mode kept", r, 32'h1234_5678);
        rd(4'd1, r); chk("R8 ctrl kept", r, 32'h0000_2002);
        rd(4'd2, r); chk("R8 status kept", r, 32'h0);
        rd(4'd3, r); chk("R8 enable kept", r, 32'h0);
        rd(4'd5, r); chk("R8 tx base kept", r, 32'h2000_0080);
        chk("R8 irq low", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule